// File: doc/BRIEF.md
# Power-of-Two Serial Clock Prescaler

This block derives the shift-clock time base of a serial peripheral engine from the fabric clock. It holds two 16-bit scaling codes, one for the transmit path and one for the receive path. Each code selects a division of the fabric clock by 1 or by a power of two up to 1024. A three-bit base code picks 1 (bypass) or 2 to 128. A separate multiplier field scales that choice by 32. For each path the block produces two outputs. One is a single-cycle enable that marks the end of every divided period, for the shift logic. The other is a serial clock waveform that rests at a selectable idle level.

Software writes a code through a plain 16-bit write port and then enables the clock. A frame-start pulse begins the divided clock. A code written while the clock runs is held back until the next frame start, so a running period is never cut short. Dropping the enable stops both paths at once and returns the waveforms to the idle level.

Top module: `sck_prescaler`

## Requirements
- R1: After reset both tick outputs are low and both clock outputs equal `idle_hi_i`. Both scaling codes reset to 0x0000, which selects a ratio of 2.
- R2: With bits 12:8 of the code zero, a low code (bits 2:0) of 0, 1, 2, 3 or 4 selects a ratio of 2, 4, 8, 16 or 32.
- R3: A low code of 7 bypasses the base divider (ratio 1). The tick is high on every cycle the path runs, and the clock output holds the level opposite to idle.
- R4: A value of 0x1F in bits 12:8 multiplies the base ratio by 32. Codes 0x1F00 to 0x1F04 give 64 to 1024, and 0x1F07 gives 32.
- R5: Unlisted codes round up to a supported ratio, capped at 1024. Low codes 5 and 6 act as 64 and 128. Any non-zero value in bits 12:8 acts as 0x1F. Any product above 1024 gives 1024.
- R6: Code bits 15:13 and 7:3 have no effect on the ratio.
- R7: Take the cycle after the clock edge that accepts a frame start as cycle 0. With ratio R ≥ 2, the tick is high in cycles R-1, 2R-1 and so on. The clock output sits at the idle level for the first R/2 cycles of each period and at the opposite level for the last R/2 (50% duty).
- R8: While `sck_en_i` is low, a frame start is ignored. A path that was running stops on the next cycle, with its tick low and its clock output at the idle level.
- R9: A code written while a path runs does not change that path's ratio until the next accepted frame start. An accepted frame start restarts the period at cycle 0 with the latest code, even part-way through a period.
- R10: `wr_sel_i` = 0 writes the transmit code and 1 writes the receive code. A write to one path leaves the other path's ratio unchanged.
- R11: `idle_hi_i` sets the idle level of both clock outputs, and the waveform of R7 is taken relative to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fabric clock, the parent of both divided clocks |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe for a scaling code |
| wr_sel_i | input | 1 | Path select for the write: 0 transmit, 1 receive |
| wr_data_i | input | 16 | Scaling code written on `wr_en_i` |
| sck_en_i | input | 1 | Clock enable for both paths |
| frame_start_i | input | 1 | Starts or restarts the divided clock when enabled |
| idle_hi_i | input | 1 | Idle level of the clock outputs |
| tx_tick_o | output | 1 | Transmit end-of-period enable pulse |
| tx_sck_o | output | 1 | Transmit serial clock waveform |
| rx_tick_o | output | 1 | Receive end-of-period enable pulse |
| rx_sck_o | output | 1 | Receive serial clock waveform |

## Verification
The assertions check several rules on every cycle. A path goes quiet one cycle after the enable drops. The active ratio stays frozen while a path runs without a frame start. The count returns to zero after every tick and after every accepted frame start. A path at ratio 2 or more falls back to the idle level right after a tick, and a bypassed path ticks on every running cycle. Only the bench scenarios can show the full code-to-ratio mapping: every low code under a zero, nominal and reserved multiplier field. They also show the exact tick cycles and duty cycle for both idle levels, the reset default code, the ignored code bits, path independence, and the deferral of a code written mid-run.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam int PSC_REG_W   = 16;
  localparam int PSC_LOW_W   = 3;
  localparam int PSC_UP_LSB  = 8;
  localparam int PSC_UP_W    = 5;
  localparam int PSC_EXT_LOG = 5;
  localparam int PSC_MAX_LOG = 10;
  localparam int PSC_LOG_W   = $clog2(PSC_MAX_LOG + 1);
  localparam logic [PSC_LOW_W-1:0] PSC_BYPASS = '1;

  typedef logic [PSC_LOG_W-1:0]   psc_log_t;
  typedef logic [PSC_MAX_LOG-1:0] psc_cnt_t;

  // log2 of the division ratio from the two code fields, rounded up and capped
  function automatic psc_log_t psc_code_to_log(input logic [PSC_LOW_W-1:0] lo,
                                               input logic [PSC_UP_W-1:0] up);
    int sum;
    sum = (lo == PSC_BYPASS) ? 0 : int'(lo) + 1;
    if (up != '0) sum = sum + PSC_EXT_LOG;
    if (sum > PSC_MAX_LOG) sum = PSC_MAX_LOG;
    return psc_log_t'(sum);
  endfunction

  // last count value of a period: 2**lg - 1
  function automatic psc_cnt_t psc_last_count(input psc_log_t lg);
    psc_cnt_t m;
    for (int i = 0; i < PSC_MAX_LOG; i++) m[i] = (i < int'(lg));
    return m;
  endfunction

  // second half of the period (always true for the bypass ratio)
  function automatic logic psc_phase(input psc_cnt_t cnt, input psc_log_t lg);
    logic ph;
    ph = 1'b1;
    for (int i = 0; i < PSC_MAX_LOG; i++)
      if (i + 1 == int'(lg)) ph = cnt[i];
    return ph;
  endfunction
endpackage

// File: rtl/psc_scale_reg.sv
module psc_scale_reg #(
  parameter int REG_W = psc_pkg::PSC_REG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] code_o
);
  logic [REG_W-1:0] code_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)   code_q <= '0;
    else if (we_i) code_q <= wdata_i;
  end

  assign code_o = code_q;
endmodule

// File: rtl/psc_ratio_hold.sv
module psc_ratio_hold
  import psc_pkg::*;
#(
  parameter int REG_W = PSC_REG_W,
  parameter int LOG_W = PSC_LOG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] code_i,
  input  logic             run_i,
  input  logic             load_i,
  output logic [LOG_W-1:0] act_log_o
);
  localparam logic [REG_W-1:0] LOW_MASK   = REG_W'({PSC_LOW_W{1'b1}});
  localparam logic [REG_W-1:0] UP_MASK    = REG_W'({PSC_UP_W{1'b1}}) << PSC_UP_LSB;
  localparam logic [REG_W-1:0] FIELD_MASK = LOW_MASK | UP_MASK;

  logic [PSC_LOW_W-1:0] lo_w;
  logic [PSC_UP_W-1:0]  up_w;
  logic [LOG_W-1:0]     next_log;
  logic [LOG_W-1:0]     act_q;
  logic                 reload_evt;
  logic                 unused_code_bits;

  assign lo_w             = code_i[PSC_LOW_W-1:0];
  assign up_w             = code_i[PSC_UP_LSB +: PSC_UP_W];
  assign unused_code_bits = ^(code_i & ~FIELD_MASK);
  assign next_log         = LOG_W'(psc_code_to_log(lo_w, up_w));
  // ratio follows the code while idle, and is captured at a frame start
  assign reload_evt       = load_i || !run_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)         act_q <= LOG_W'(psc_code_to_log('0, '0));
    else if (reload_evt) act_q <= next_log;
  end

  assign act_log_o = act_q;
endmodule

// File: rtl/psc_div_core.sv
module psc_div_core
  import psc_pkg::*;
#(
  parameter int CNT_W = PSC_MAX_LOG,
  parameter int LOG_W = PSC_LOG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_i,
  input  logic [LOG_W-1:0] act_log_i,
  input  logic             idle_hi_i,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tick_o,
  output logic             sck_o
);
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;
  logic             wrap_evt;
  logic             phase_w;

  assign last_cnt = CNT_W'(psc_last_count(psc_log_t'(act_log_i)));
  assign wrap_evt = run_q && (cnt_q == last_cnt);
  assign phase_w  = psc_phase(psc_cnt_t'(cnt_q), psc_log_t'(act_log_i));

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !en_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q) begin
      cnt_q <= wrap_evt ? '0 : cnt_q + 1'b1;
    end
  end

  assign run_o  = run_q;
  assign cnt_o  = cnt_q;
  assign tick_o = wrap_evt;
  assign sck_o  = idle_hi_i ^ (run_q & phase_w);
endmodule

// File: rtl/sck_prescaler.sv
module sck_prescaler #(
  parameter int REG_W   = psc_pkg::PSC_REG_W,
  parameter int MAX_LOG = psc_pkg::PSC_MAX_LOG
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             sck_en_i,
  input  logic             frame_start_i,
  input  logic             idle_hi_i,
  output logic             tx_tick_o,
  output logic             tx_sck_o,
  output logic             rx_tick_o,
  output logic             rx_sck_o
);
  localparam int NCH   = 2;
  localparam int LOG_W = $clog2(MAX_LOG + 1);
  localparam int CNT_W = MAX_LOG;

  logic                        start_w;
  logic [NCH-1:0][REG_W-1:0]   code_w;
  logic [NCH-1:0][LOG_W-1:0]   act_log_w;
  logic [NCH-1:0][CNT_W-1:0]   cnt_w;
  logic [NCH-1:0]              run_w;
  logic [NCH-1:0]              tick_w;
  logic [NCH-1:0]              sck_w;

  // accepted frame start, shared by both paths
  assign start_w = frame_start_i && sck_en_i;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic we_w;
    assign we_w = wr_en_i && (wr_sel_i == 1'(g));

    psc_scale_reg #(.REG_W(REG_W)) reg_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (we_w),
      .wdata_i (wr_data_i),
      .code_o  (code_w[g])
    );

    psc_ratio_hold #(.REG_W(REG_W), .LOG_W(LOG_W)) hold_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .code_i    (code_w[g]),
      .run_i     (run_w[g]),
      .load_i    (start_w),
      .act_log_o (act_log_w[g])
    );

    psc_div_core #(.CNT_W(CNT_W), .LOG_W(LOG_W)) div_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (sck_en_i),
      .start_i   (start_w),
      .act_log_i (act_log_w[g]),
      .idle_hi_i (idle_hi_i),
      .run_o     (run_w[g]),
      .cnt_o     (cnt_w[g]),
      .tick_o    (tick_w[g]),
      .sck_o     (sck_w[g])
    );
  end

  assign tx_tick_o = tick_w[0];
  assign tx_sck_o  = sck_w[0];
  assign rx_tick_o = tick_w[1];
  assign rx_sck_o  = sck_w[1];
endmodule

// File: rtl/psc_checker.sv
module psc_checker #(
  parameter int NCH   = 2,
  parameter int LOG_W = 4,
  parameter int CNT_W = 10
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      sck_en_i,
  input logic                      frame_start_i,
  input logic                      idle_hi_i,
  input logic [NCH-1:0]            run,
  input logic [NCH-1:0]            tick,
  input logic [NCH-1:0]            sck,
  input logic [NCH-1:0][LOG_W-1:0] act_log,
  input logic [NCH-1:0][CNT_W-1:0] cnt
);
  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R8
    en_off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sck_en_i |=> (!tick[g] && !run[g]));

    // R8
    en_off_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sck_en_i |=> (sck[g] == idle_hi_i));

    // R9
    ratio_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run[g] && sck_en_i && !frame_start_i) |=> $stable(act_log[g]));

    // R9
    start_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frame_start_i && sck_en_i) |=> (run[g] && cnt[g] == '0));

    // R7
    wrap_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick[g] && sck_en_i && !frame_start_i) |=> (run[g] && cnt[g] == '0));

    // R7
    wrap_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick[g] && act_log[g] != '0 && sck_en_i && !frame_start_i) |=> (sck[g] == idle_hi_i));

    // R3
    bypass_every_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run[g] && act_log[g] == '0) |-> tick[g]);
  end
endmodule

bind sck_prescaler psc_checker #(.NCH(NCH), .LOG_W(LOG_W), .CNT_W(CNT_W)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sck_en_i      (sck_en_i),
  .frame_start_i (frame_start_i),
  .idle_hi_i     (idle_hi_i),
  .run           (run_w),
  .tick          (tick_w),
  .sck           (sck_w),
  .act_log       (act_log_w),
  .cnt           (cnt_w)
);

// File: tb/sck_prescaler_tb_top.sv
module sck_prescaler_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_sel, sck_en, frame_start, idle_hi;
  logic [15:0] wr_data;
  logic        tx_tick_o, tx_sck_o, rx_tick_o, rx_sck_o;
  int          total = 0;
  int          bad = 0;
  int          cyc = 0;

  always #4 clk = ~clk;

  sck_prescaler dut_i (
    .clk_i (clk), .rst_ni (rst_n), .wr_en_i (wr_en), .wr_sel_i (wr_sel),
    .wr_data_i (wr_data), .sck_en_i (sck_en), .frame_start_i (frame_start),
    .idle_hi_i (idle_hi), .tx_tick_o (tx_tick_o), .tx_sck_o (tx_sck_o),
    .rx_tick_o (rx_tick_o), .rx_sck_o (rx_sck_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=fewer", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // ratio from the requirements: 2 << lo, bypass 1, x32 field, cap 1024
  function automatic int exp_ratio(input int code);
    int lo, up, r;
    lo = code & 7;
    up = (code >> 8) & 31;
    r  = (lo == 7) ? 1 : (2 << lo);
    if (up != 0) r = r * 32;
    if (r > 1024) r = 1024;
    return r;
  endfunction

  function automatic string tag_for(input int code);
    int lo, up;
    lo = code & 7;
    up = (code >> 8) & 31;
    if ((code & 16'hE0F8) != 0) return "R6";
    if ((up != 0 && up != 31) || lo == 5 || lo == 6) return "R5";
    if (lo == 7) return "R3";
    if (up == 31) return "R4";
    return "R2";
  endfunction

  function automatic int exp_sck(input int i, input int r, input int idle);
    int act;
    act = (r == 1) ? 1 : (((i % r) >= r / 2) ? 1 : 0);
    return idle ^ act;
  endfunction

  task automatic wr(input logic sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // sample i counts cycles after the accepting edge (R7, R11)
  task automatic expect_slot(input int i, input int rt, input int rr,
                             input string tt, input string tr);
    chk(tt, "tx tick", int'(tx_tick_o), ((i % rt) == rt - 1) ? 1 : 0);
    chk($sformatf("%s R7 R11", tt), "tx sck", int'(tx_sck_o), exp_sck(i, rt, int'(idle_hi)));
    chk($sformatf("%s R10", tr), "rx tick", int'(rx_tick_o), ((i % rr) == rr - 1) ? 1 : 0);
    chk($sformatf("%s R7 R10", tr), "rx sck", int'(rx_sck_o), exp_sck(i, rr, int'(idle_hi)));
  endtask

  task automatic check_quiet(input string tag);
    chk(tag, "tx tick quiet", int'(tx_tick_o), 0);
    chk(tag, "rx tick quiet", int'(rx_tick_o), 0);
    chk(tag, "tx sck idle", int'(tx_sck_o), int'(idle_hi));
    chk(tag, "rx sck idle", int'(rx_sck_o), int'(idle_hi));
  endtask

  task automatic run_pair(input int txc, input int rxc, input logic cp);
    int rt, rr, n;
    rt = exp_ratio(txc);
    rr = exp_ratio(rxc);
    n  = 2 * ((rt > rr) ? rt : rr);
    @(negedge clk);
    sck_en = 1'b0; idle_hi = cp;
    wr(1'b0, 16'(txc));
    wr(1'b1, 16'(rxc));
    @(negedge clk);
    sck_en = 1'b1; frame_start = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frame_start = 1'b0;
      expect_slot(i, rt, rr, tag_for(txc), tag_for(rxc));
    end
    sck_en = 1'b0;
    @(negedge clk);
    check_quiet("R8");
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
    sck_en = 1'b0; frame_start = 1'b0; idle_hi = 1'b0;
    repeat (2) @(negedge clk);
    check_quiet("R1");
    idle_hi = 1'b1;
    @(negedge clk);
    check_quiet("R1");
    idle_hi = 1'b0;
    rst_n = 1'b1;

    // R1: reset code gives ratio 2 on both paths
    @(negedge clk);
    sck_en = 1'b1; frame_start = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      frame_start = 1'b0;
      expect_slot(i, 2, 2, "R1", "R1");
    end
    sck_en = 1'b0;
    @(negedge clk);
    check_quiet("R8");

    // R8: frame start without enable is ignored
    frame_start = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check_quiet("R8");
    end
    frame_start = 1'b0;

    // R2 R3 R4 R5 R10 R11: sweep every low code under three multiplier fields
    for (int cp = 0; cp < 2; cp++) begin
      for (int u = 0; u < 3; u++) begin
        for (int lo = 0; lo < 8; lo++) begin
          int up;
          up = (u == 0) ? 0 : ((u == 1) ? 31 : 5);
          run_pair((up << 8) | lo, (up << 8) | ((lo + 3) % 8), cp[0]);
        end
      end
    end

    // R6: bits outside the two fields are ignored
    run_pair(16'hE0F9, 16'hFFFF, 1'b1);

    // R9: a write while running is deferred; a frame start restarts mid-period
    @(negedge clk);
    idle_hi = 1'b0;
    wr(1'b0, 16'h0001);
    @(negedge clk);
    sck_en = 1'b1; frame_start = 1'b1;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      frame_start = 1'b0;
      chk("R9", "tx tick old ratio", int'(tx_tick_o), ((i % 4) == 3) ? 1 : 0);
      chk("R9", "tx sck old ratio", int'(tx_sck_o), exp_sck(i, 4, 0));
      wr_en = (i == 5); wr_sel = 1'b0; wr_data = 16'h0000;
      if (i == 13) frame_start = 1'b1;
    end
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      frame_start = 1'b0;
      chk("R9", "tx tick new ratio", int'(tx_tick_o), ((j % 2) == 1) ? 1 : 0);
      chk("R9", "tx sck new ratio", int'(tx_sck_o), exp_sck(j, 2, 0));
    end
    sck_en = 1'b0;
    @(negedge clk);
    check_quiet("R8");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule